// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block sits on a two-wire serial bus as a fixed-address slave and exposes a bank of six 8-bit configuration registers. Those registers drive the output enables, the amplitude selection and the byte-count setting of a clock generator. Both bus lines are sampled in the system clock domain. Start and stop conditions, SCL edges and data bits are recovered from those samples. The slave pulls SDA low through an output-enable pin only during an acknowledge bit or a transmitted 0 bit.

A master reaches the bank in one of four ways: single-byte write, single-byte read, counted block write and counted block read. The command byte that follows the write address selects the access mode and the register where the transfer starts. Consecutive bytes then advance through the registers, and after the last register the index returns to register 0. A block read begins with a count byte taken from the byte-count register (index 4), and the register data follows it.

The register contents leave the block as one flat parallel vector. Byte i sits in bits 8i+7 down to 8i. The serial line has no valid/ready interface: the master paces every transfer with SCL, and the slave neither stretches the clock nor applies back-pressure. It can only refuse a byte by not acknowledging it.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset the registers hold 0x04, 0x00, 0xC0, 0x08, 0x06 and 0xD8 at indices 0 to 5, with byte i on regs_o[8i+7:8i], and SDA is released (sda_oe = 0).
- R2: The slave acknowledges only the 7-bit address 0x6B: address byte 0xD6 for a write and 0xD7 for a read. For any other address it leaves SDA released for the acknowledge bit and for every later byte until the next start, and it changes no register.
- R3: In the command byte, bit 7 = 1 selects a single-byte access and bit 7 = 0 selects a block access. Bits 6:0 give the starting register, and a value of 6 or more starts at register 0.
- R4: A single-byte write acknowledges the address, the command and the data byte, and the addressed register takes the data. A register changes only while the slave is driving an acknowledge.
- R5: In a single-byte write, a second data byte is not acknowledged and is not stored.
- R6: A single-byte read (write address, command, repeated start, read address) returns the addressed register MSB first.
- R7: A block write takes a count byte after the command and then stores that many data bytes into consecutive registers, wrapping from 5 to 0. Each of those bytes is acknowledged. The byte after the last counted one gets no acknowledge and is not stored, so a count of 0 refuses the first data byte.
- R8: A block read first returns the current value of register 4 and then the registers from the starting index upward, wrapping from 5 to 0. The slave keeps sending while the master acknowledges and stops at the master's not-acknowledge.
- R9: A stop condition at any point releases SDA and ends the transfer. A partly received byte is discarded.
- R10: The slave changes SDA only while SCL is low. It sends every byte most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset to the register defaults |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| regs_o | output | 48 | Register bank, byte i on bits 8i+7:8i |

## Verification
A wrong link state shows up at the pins within one bit time. It appears as an acknowledge where none is due (or a missing one), or as a read bit that differs from the register image, and the master samples both in the next SCL high phase. A wrong index or remaining-count value shows up as a wrong register in regs_o, visible a few system clocks after the acknowledge edge, or as a mis-ordered byte in a block read. Between transfers the bench compares the whole register vector and the SDA enable against its own register image on every clock, so a stray write outside an acknowledge is caught in the quiet window that follows.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_CMD,
    LK_CNT,
    LK_WDAT,
    LK_ACK,
    LK_TX,
    LK_MACK
  } link_state_t;

  // Power-up image of one register slot
  function automatic logic [7:0] reg_default(input int unsigned slot);
    case (slot)
      0:       return 8'h04;
      2:       return 8'hC0;
      3:       return 8'h08;
      4:       return 8'h06;
      5:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC-1:0] scl_q, sda_q;
  logic            scl_p, sda_p;
  logic            scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_q[SYNC-1];
      sda_p <= sda_q[SYNC-1];
    end
  end

  assign scl_s     = scl_q[SYNC-1];
  assign sda_s     = sda_q[SYNC-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/tws_regbank.sv
module tws_regbank #(
  parameter int NREG = 6,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [7:0]         rd_data,
  output logic [NREG*8-1:0]  regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_o[g*8 +: 8] <= tws_pkg::reg_default(g);
      else if (wr_en && wr_idx == IDXW'(g))
        regs_o[g*8 +: 8] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NREG; k++)
      if (rd_idx == IDXW'(k)) rd_data = regs_o[k*8 +: 8];
  end

endmodule

// File: rtl/tws_link.sv
module tws_link
  import tws_pkg::*;
#(
  parameter int          NREG     = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h6B,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic [7:0]      rd_data,
  input  logic [7:0]      cnt_val,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            sda_oe
);

  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NREG - 1);
  localparam logic [7:0]      NREG8    = 8'(NREG);

  link_state_t      st, after_ack;
  logic [7:0]       sr;
  logic [3:0]       bitcnt;
  logic [IDXW-1:0]  idx;
  logic             blk, cnt_first, m_ack;
  logic [7:0]       left;
  logic [7:0]       tx_byte;
  logic [IDXW-1:0]  idx_inc;

  assign idx_inc = (idx == IDX_LAST) ? '0 : idx + 1'b1;
  assign tx_byte = cnt_first ? cnt_val : rd_data;
  assign rd_idx  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LK_IDLE;
      after_ack <= LK_IDLE;
      sr        <= '0;
      bitcnt    <= '0;
      idx       <= '0;
      blk       <= 1'b0;
      cnt_first <= 1'b0;
      m_ack     <= 1'b0;
      left      <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st     <= LK_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_ADDR, LK_CMD, LK_CNT, LK_WDAT: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sr     <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              st     <= LK_ACK;
              sda_oe <= 1'b1;
              case (st)
                LK_ADDR: begin
                  if (sr[7:1] != DEV_ADDR) begin
                    st     <= LK_IDLE;
                    sda_oe <= 1'b0;
                  end else if (sr[0]) begin
                    after_ack <= LK_TX;
                    cnt_first <= blk;
                  end else begin
                    after_ack <= LK_CMD;
                  end
                end
                LK_CMD: begin
                  idx       <= ({1'b0, sr[6:0]} < NREG8) ? sr[IDXW-1:0] : '0;
                  blk       <= ~sr[7];
                  left      <= 8'd1;
                  after_ack <= sr[7] ? LK_WDAT : LK_CNT;
                end
                LK_CNT: begin
                  left      <= sr;
                  after_ack <= LK_WDAT;
                end
                default: begin
                  if (left == 8'd0) begin
                    st     <= LK_IDLE;
                    sda_oe <= 1'b0;
                  end else begin
                    wr_en     <= 1'b1;
                    wr_idx    <= idx;
                    wr_data   <= sr;
                    idx       <= idx_inc;
                    left      <= left - 8'd1;
                    after_ack <= LK_WDAT;
                  end
                end
              endcase
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              st     <= after_ack;
              sda_oe <= 1'b0;
              if (after_ack == LK_TX) begin
                sda_oe    <= ~tx_byte[7];
                sr        <= {tx_byte[6:0], 1'b0};
                bitcnt    <= 4'd1;
                cnt_first <= 1'b0;
                if (!cnt_first) idx <= idx_inc;
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (bitcnt != 4'd8) begin
                sda_oe <= ~sr[7];
                sr     <= {sr[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end else begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= LK_MACK;
              end
            end
          end
          LK_MACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            else if (scl_fall) begin
              if (m_ack) begin
                st        <= LK_TX;
                sda_oe    <= ~tx_byte[7];
                sr        <= {tx_byte[6:0], 1'b0};
                bitcnt    <= 4'd1;
                cnt_first <= 1'b0;
                if (!cnt_first) idx <= idx_inc;
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave #(
  parameter int         NREG     = 6,
  parameter int         CNT_REG  = 4,
  parameter int         SYNC     = 2,
  parameter logic [6:0] DEV_ADDR = 7'h6B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  localparam int IDXW = $clog2(NREG);

  logic            sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [7:0]      wr_data, rd_data;

  tws_line_sync #(.SYNC(SYNC)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tws_link #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .cnt_val   (regs_o[CNT_REG*8 +: 8]),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  tws_regbank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int NREG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic              stop_evt,
  input logic              we
);

  function automatic logic [NREG*8-1:0] all_defaults();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = tws_pkg::reg_default(k);
    return v;
  endfunction

  logic wrote_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wrote_seen <= 1'b0;
    else if (we) wrote_seen <= 1'b1;
  end

  assert_defaults_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrote_seen |-> regs_o == all_defaults());

  assert_write_under_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o != $past(regs_o)) |-> sda_oe);

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

endmodule

bind clkcfg_serial_slave tws_checker #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .regs_o   (regs_o),
  .stop_evt (stop_evt),
  .we       (wr_en)
);

// File: tb/sim_clkcfg_serial_slave.sv
module sim_clkcfg_serial_slave;
  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  clkcfg_serial_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [7:0] mdl [NREG];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] cmd);
    return (int'(cmd[6:0]) < NREG) ? int'(cmd[6:0]) : 0;
  endfunction

  function automatic int nxt(input int i);
    return (i == NREG - 1) ? 0 : i + 1;
  endfunction

  // Per-clock comparison of the register image between transfers (R1, R4, R9)
  always @(negedge clk) begin
    if (quiet && rst_n) begin
      for (int k = 0; k < NREG; k++)
        if (regs[k*8 +: 8] !== mdl[k])
          check(1'b0, "R4 quiet image", regs[k*8 +: 8], mdl[k]);
      check(sda_oe === 1'b0, "R9 quiet sda released", sda_oe, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(4*Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic byte_out(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic byte_in(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(nack);
  endtask

  task automatic open_write(input logic [7:0] cmd);
    bit a;
    quiet = 1'b0;
    bstart();
    byte_out(8'hD6, a); check(a, "R2 write address ack", a, 1);
    byte_out(cmd, a);   check(a, "R3 command ack", a, 1);
  endtask

  task automatic wr_byte(input logic [7:0] cmd, input logic [7:0] d);
    bit a;
    open_write(cmd | 8'h80);
    byte_out(d, a); check(a, "R4 data ack", a, 1);
    mdl[eff(cmd)] = d;
    bstop(); quiet = 1'b1;
    check(regs[eff(cmd)*8 +: 8] === d, "R4 register updated", regs[eff(cmd)*8 +: 8], d);
  endtask

  task automatic rd_byte(input logic [7:0] cmd);
    bit a; logic [7:0] d;
    open_write(cmd | 8'h80);
    bstart();
    byte_out(8'hD7, a); check(a, "R2 read address ack", a, 1);
    byte_in(1'b1, d);
    check(d === mdl[eff(cmd)], "R6 byte read data", d, mdl[eff(cmd)]);
    bstop(); quiet = 1'b1;
  endtask

  task automatic blk_wr(input logic [7:0] cmd, input int cnt, input logic [7:0] base);
    bit a; int i_r;
    open_write(cmd & 8'h7F);
    byte_out(8'(cnt), a); check(a, "R7 count ack", a, 1);
    i_r = eff(cmd);
    for (int i = 0; i <= cnt; i++) begin
      byte_out(base + 8'(i), a);
      check(a == (i < cnt), "R7 block data ack", a, (i < cnt));
      if (!a) break;
      mdl[i_r] = base + 8'(i);
      i_r = nxt(i_r);
    end
    bstop(); quiet = 1'b1;
  endtask

  task automatic blk_rd(input logic [7:0] cmd, input int n);
    bit a; logic [7:0] d; int i_r;
    open_write(cmd & 8'h7F);
    bstart();
    byte_out(8'hD7, a); check(a, "R2 read address ack", a, 1);
    byte_in(1'b0, d);
    check(d === mdl[4], "R8 leading count byte", d, mdl[4]);
    i_r = eff(cmd);
    for (int i = 0; i < n; i++) begin
      byte_in(i == n - 1, d);
      check(d === mdl[i_r], "R8 block read data", d, mdl[i_r]);
      i_r = nxt(i_r);
    end
    bstop(); quiet = 1'b1;
  endtask

  initial begin
    bit a;
    mdl[0] = 8'h04; mdl[1] = 8'h00; mdl[2] = 8'hC0;
    mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
    tick(5); rst_n = 1'b1; tick(3);
    for (int k = 0; k < NREG; k++)
      check(regs[k*8 +: 8] === mdl[k], "R1 reset default", regs[k*8 +: 8], mdl[k]);
    check(sda_oe === 1'b0, "R1 sda released at reset", sda_oe, 0);
    quiet = 1'b1;

    rd_byte(8'h02);                 // R6 default C0
    wr_byte(8'h01, 8'h5A);          // R4
    rd_byte(8'h01);                 // R6, R10 MSB-first pattern
    wr_byte(8'h10, 8'h33);          // R3 out-of-range index lands on 0
    rd_byte(8'h00);

    // R5: second data byte in a single-byte write
    open_write(8'h83);
    byte_out(8'hA5, a); check(a, "R5 first data ack", a, 1);
    mdl[3] = 8'hA5;
    byte_out(8'h3C, a); check(!a, "R5 extra byte refused", a, 0);
    bstop(); quiet = 1'b1;
    check(regs[4*8 +: 8] === mdl[4], "R5 next register untouched", regs[4*8 +: 8], mdl[4]);

    // R2: foreign addresses
    quiet = 1'b0;
    bstart();
    byte_out(8'hA6, a); check(!a, "R2 foreign address refused", a, 0);
    byte_out(8'h81, a); check(!a, "R2 later byte ignored", a, 0);
    byte_out(8'hFF, a); check(!a, "R2 later byte ignored", a, 0);
    bstop(); quiet = 1'b1;
    quiet = 1'b0;
    bstart();
    byte_out(8'hD5, a); check(!a, "R2 neighbour read address refused", a, 0);
    bstop(); quiet = 1'b1;

    blk_wr(8'h04, 3, 8'h03);        // R7 writes 4,5 then wraps to 0
    blk_rd(8'h05, 3);               // R8 count then 5,0,1
    blk_wr(8'h02, 0, 8'h77);        // R7 zero count
    blk_rd(8'h09, 2);               // R3/R8 out-of-range block start

    // R9: stop in the middle of a data byte
    open_write(8'h81);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bstop(); quiet = 1'b1;
    check(sda_oe === 1'b0, "R9 sda after stop", sda_oe, 0);
    check(regs[1*8 +: 8] === mdl[1], "R9 partial byte discarded", regs[1*8 +: 8], mdl[1]);
    rd_byte(8'h05);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule